// File: doc/BRIEF.md
# Sleep-Instruction Power Mode Sequencer

This block decides where the processor goes when it executes a sleep instruction. It holds the present operating mode and reads five control bits: standby select, low-speed enable, medium-speed enable, direct-transition enable and timer watch enable. When the bits name a defined direct transition, the block enters an intermediate low-power state and waits a short settling time on the oscillator. It then switches the CPU clock source and divider and times the interrupt exception handling on the new clock. At the end of that phase it raises a one-cycle done pulse. In every other case it parks in a plain low-power mode until a wake interrupt arrives.

Oscillator and watch-clock periods reach the block as single-cycle tick strobes on its own clock. The wake interrupt is also a plain strobe. The two clock outputs tell the clock generator which source to use and which divider ratio to apply.

Top module: `lpm_sequencer`

## Requirements
- R1: After a synchronous reset the mode output is high-speed active (code 0). The clock source is the oscillator (clkSrc 0), the divider code is 0, and busy and xferDone are both low.
- R2: With the mode at high-speed active, a sleep request with directOn=1, medSpdOn=1, stbySel=0 and lowSpdOn=0 first shows sleep mode (code 3) with busy high. It then ends in medium-speed active mode (code 1) with clkSrc 0 and divSel equal to medDiv.
- R3: With the mode at high-speed active, a sleep request with directOn=1, stbySel=1, tmrWatch=1 and lowSpdOn=1 first shows watch mode (code 5) with busy high. It then ends in subactive mode (code 2) with clkSrc 1 (watch clock) and divSel equal to subDiv.
- R4: The intermediate state of a direct transition lasts exactly 3 oscillator ticks, and the clock setting changes after the third.
- R5: The exception-handling phase lasts 14 CPU clock periods, counted as 14 × d ticks of the newly selected source. The divider code gives d as follows: 0 gives 1, 1 gives 8, 2 gives 16, 3 gives 32. A change to the oscillator divided by 8 therefore takes 115 oscillator ticks in total.
- R6: xferDone is high for exactly one cycle at the end of the exception phase, and busy is low in that cycle.
- R7: With directOn=0, a sleep request enters a plain low-power mode. stbySel=0 gives sleep (3). stbySel=1 with tmrWatch=0 gives standby (4). stbySel=1 with tmrWatch=1 gives watch (5). The mode stays there, with the clock unchanged, until wakeIrq, and then returns to the active mode it left.
- R8: With directOn=1, a bit combination that is not one of the two direct transitions, or a request from a mode other than high-speed active, enters sleep mode (3). The clock setting is left unchanged, and the mode returns to the previous active mode on wakeIrq.
- R9: sleepReq and wakeIrq have no effect while a direct transition is in progress, and sleepReq has no effect while parked in a low-power mode. Neither the mode nor the transition timing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| sleepReq | input | 1 | Sleep instruction executed (one-cycle strobe) |
| wakeIrq | input | 1 | Wake interrupt strobe |
| stbySel | input | 1 | Standby select control bit |
| lowSpdOn | input | 1 | Low-speed enable control bit |
| medSpdOn | input | 1 | Medium-speed enable control bit |
| directOn | input | 1 | Direct-transition enable control bit |
| tmrWatch | input | 1 | Timer watch enable control bit |
| medDiv | input | 2 | Divider code for medium-speed active mode |
| subDiv | input | 2 | Divider code for subactive mode |
| oscTick | input | 1 | One pulse per oscillator period |
| watchTick | input | 1 | One pulse per watch-clock period |
| mode | output | 3 | Current mode code |
| clkSrc | output | 1 | CPU clock source: 0 oscillator, 1 watch clock |
| divSel | output | 2 | CPU clock divider code |
| busy | output | 1 | Direct transition in progress |
| xferDone | output | 1 | One-cycle pulse when exception handling ends |

## Verification
On every cycle the embedded properties check four things. The done pulse lasts one cycle. The clock setting moves only on the controller's load strobe. The phase counters stay below their limits. The mode does not drift while parked or mid-transition. Only the bench scenarios can show that the phases last the right number of ticks for each divider code and source, and that the mode and clock reached are correct for all 32 control-bit combinations. They also show that a request or wake arriving mid-transition leaves both timing and target alone.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    MODE_ACT_HI  = 3'd0,
    MODE_ACT_MED = 3'd1,
    MODE_SUBACT  = 3'd2,
    MODE_SLEEP   = 3'd3,
    MODE_STBY    = 3'd4,
    MODE_WATCH   = 3'd5
  } lpMode_e;

  typedef enum logic [1:0] {
    ST_RUN,
    ST_PARK,
    ST_SETTLE,
    ST_EXC
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       clrCnt;
    logic       cntOsc;
    logic       cntSel;
    logic       loadClk;
    logic       newSrc;
    logic [1:0] newDiv;
  } ctlStrobe_t;

  localparam int unsigned MAX_DIV = 32;

  // divider code -> division ratio: 0:/1, 1:/8, 2:/16, 3:/32
  function automatic int unsigned divFactor(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (32'd4 << code);
  endfunction

endpackage

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 3,
  parameter int unsigned EXC_CYCLES    = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  ctlStrobe_t strobe,
  input  logic       oscTick,
  input  logic       watchTick,
  output logic       clkSrc,
  output logic [1:0] divSel,
  output logic       settleLast,
  output logic       excLast
);

  localparam int unsigned EXC_MAX  = EXC_CYCLES * MAX_DIV;
  localparam int unsigned CNT_MAX  = (EXC_MAX > SETTLE_CYCLES) ? EXC_MAX : SETTLE_CYCLES;
  localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] excLimit;
  logic             selTick;
  logic             cntStep;

  assign selTick  = clkSrc ? watchTick : oscTick;
  assign excLimit = CNT_W'(EXC_CYCLES * divFactor(divSel));
  assign cntStep  = (strobe.cntOsc && oscTick) || (strobe.cntSel && selTick);

  assign settleLast = strobe.cntOsc && oscTick && (cnt == CNT_W'(SETTLE_CYCLES - 1));
  assign excLast    = strobe.cntSel && selTick && (cnt == excLimit - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      clkSrc <= 1'b0;
      divSel <= 2'd0;
    end else begin
      if (strobe.clrCnt)
        cnt <= '0;
      else if (cntStep)
        cnt <= cnt + CNT_W'(1);
      if (strobe.loadClk) begin
        clkSrc <= strobe.newSrc;
        divSel <= strobe.newDiv;
      end
    end
  end

  // clock setting moves only on a load request (R8)
  p_clk_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strobe.loadClk |=> ($stable(clkSrc) && $stable(divSel)));

  // settle counter never passes its limit (R4)
  p_settle_bound_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.cntOsc |-> (cnt < CNT_W'(SETTLE_CYCLES)));

  // exception counter never passes 14 x divider (R5)
  p_exc_bound_r5: assert property (@(posedge clk) disable iff (rst)
    strobe.cntSel |-> (cnt < excLimit));

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sleepReq,
  input  logic       wakeIrq,
  input  logic       stbySel,
  input  logic       lowSpdOn,
  input  logic       medSpdOn,
  input  logic       directOn,
  input  logic       tmrWatch,
  input  logic [1:0] medDiv,
  input  logic [1:0] subDiv,
  input  logic       settleLast,
  input  logic       excLast,
  output ctlStrobe_t strobe,
  output lpMode_e    mode,
  output logic       busy,
  output logic       xferDone
);

  seqState_e stateQ, stateD;
  lpMode_e   modeQ, modeD, retQ, retD, tgtModeQ, tgtModeD;
  logic      tgtSrcQ, tgtSrcD;
  logic [1:0] tgtDivQ, tgtDivD;
  logic      doneQ, doneD;
  logic      goMed, goSub;
  lpMode_e   plainMode;

  assign goMed = (modeQ == MODE_ACT_HI) && directOn && !stbySel && !lowSpdOn && medSpdOn;
  assign goSub = (modeQ == MODE_ACT_HI) && directOn && stbySel && tmrWatch && lowSpdOn;

  always_comb begin
    if (directOn || !stbySel) plainMode = MODE_SLEEP;
    else if (tmrWatch)        plainMode = MODE_WATCH;
    else                      plainMode = MODE_STBY;
  end

  always_comb begin
    stateD        = stateQ;
    modeD         = modeQ;
    retD          = retQ;
    tgtModeD      = tgtModeQ;
    tgtSrcD       = tgtSrcQ;
    tgtDivD       = tgtDivQ;
    doneD         = 1'b0;
    strobe        = '0;
    strobe.newSrc = tgtSrcQ;
    strobe.newDiv = tgtDivQ;
    case (stateQ)
      ST_RUN: begin
        if (sleepReq) begin
          strobe.clrCnt = 1'b1;
          retD          = modeQ;
          if (goMed) begin
            stateD   = ST_SETTLE;
            modeD    = MODE_SLEEP;
            tgtModeD = MODE_ACT_MED;
            tgtSrcD  = 1'b0;
            tgtDivD  = medDiv;
          end else if (goSub) begin
            stateD   = ST_SETTLE;
            modeD    = MODE_WATCH;
            tgtModeD = MODE_SUBACT;
            tgtSrcD  = 1'b1;
            tgtDivD  = subDiv;
          end else begin
            stateD = ST_PARK;
            modeD  = plainMode;
          end
        end
      end
      ST_PARK: begin
        if (wakeIrq) begin
          stateD = ST_RUN;
          modeD  = retQ;
        end
      end
      ST_SETTLE: begin
        strobe.cntOsc = 1'b1;
        if (settleLast) begin
          strobe.loadClk = 1'b1;
          strobe.clrCnt  = 1'b1;
          stateD         = ST_EXC;
          modeD          = tgtModeQ;
        end
      end
      ST_EXC: begin
        strobe.cntSel = 1'b1;
        if (excLast) begin
          stateD = ST_RUN;
          doneD  = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ   <= ST_RUN;
      modeQ    <= MODE_ACT_HI;
      retQ     <= MODE_ACT_HI;
      tgtModeQ <= MODE_ACT_HI;
      tgtSrcQ  <= 1'b0;
      tgtDivQ  <= 2'd0;
      doneQ    <= 1'b0;
    end else begin
      stateQ   <= stateD;
      modeQ    <= modeD;
      retQ     <= retD;
      tgtModeQ <= tgtModeD;
      tgtSrcQ  <= tgtSrcD;
      tgtDivQ  <= tgtDivD;
      doneQ    <= doneD;
    end
  end

  assign mode     = modeQ;
  assign busy     = (stateQ == ST_SETTLE) || (stateQ == ST_EXC);
  assign xferDone = doneQ;

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    xferDone |=> !xferDone);

  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    xferDone |-> !busy);

  p_park_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_PARK && !wakeIrq) |=> $stable(mode));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !settleLast && !excLast) |=> $stable(mode));

  p_inter_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_SETTLE) |-> (mode == MODE_SLEEP || mode == MODE_WATCH));

  p_exc_active_r3: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_EXC) |-> (mode == MODE_ACT_MED || mode == MODE_SUBACT));

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int unsigned SETTLE_CYCLES = 3,
  parameter int unsigned EXC_CYCLES    = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sleepReq,
  input  logic       wakeIrq,
  input  logic       stbySel,
  input  logic       lowSpdOn,
  input  logic       medSpdOn,
  input  logic       directOn,
  input  logic       tmrWatch,
  input  logic [1:0] medDiv,
  input  logic [1:0] subDiv,
  input  logic       oscTick,
  input  logic       watchTick,
  output logic [2:0] mode,
  output logic       clkSrc,
  output logic [1:0] divSel,
  output logic       busy,
  output logic       xferDone
);

  ctlStrobe_t strobe;
  lpMode_e    modeInt;
  logic       settleLast;
  logic       excLast;

  lpm_ctrl i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sleepReq  (sleepReq),
    .wakeIrq   (wakeIrq),
    .stbySel   (stbySel),
    .lowSpdOn  (lowSpdOn),
    .medSpdOn  (medSpdOn),
    .directOn  (directOn),
    .tmrWatch  (tmrWatch),
    .medDiv    (medDiv),
    .subDiv    (subDiv),
    .settleLast(settleLast),
    .excLast   (excLast),
    .strobe    (strobe),
    .mode      (modeInt),
    .busy      (busy),
    .xferDone  (xferDone)
  );

  lpm_datapath #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .EXC_CYCLES   (EXC_CYCLES)
  ) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .oscTick   (oscTick),
    .watchTick (watchTick),
    .clkSrc    (clkSrc),
    .divSel    (divSel),
    .settleLast(settleLast),
    .excLast   (excLast)
  );

  assign mode = modeInt;

endmodule

// File: tb/test_lpm_sequencer.sv
module test_lpm_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int M_HI = 0, M_MED = 1, M_SUB = 2, M_SLEEP = 3, M_STBY = 4, M_WATCH = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleepReq = 1'b0, wakeIrq = 1'b0;
  logic stbySel = 1'b0, lowSpdOn = 1'b0, medSpdOn = 1'b0, directOn = 1'b0, tmrWatch = 1'b0;
  logic [1:0] medDiv = 2'd0, subDiv = 2'd0;
  logic oscTick = 1'b0, watchTick = 1'b0;
  logic [2:0] mode;
  logic clkSrc;
  logic [1:0] divSel;
  logic busy, xferDone;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer i_lpm_sequencer (
    .clk(clk), .rst(rst), .sleepReq(sleepReq), .wakeIrq(wakeIrq),
    .stbySel(stbySel), .lowSpdOn(lowSpdOn), .medSpdOn(medSpdOn),
    .directOn(directOn), .tmrWatch(tmrWatch), .medDiv(medDiv), .subDiv(subDiv),
    .oscTick(oscTick), .watchTick(watchTick), .mode(mode), .clkSrc(clkSrc),
    .divSel(divSel), .busy(busy), .xferDone(xferDone)
  );

  // tick generation and tick accounting, one process at the falling edge
  int cyc = 0;
  int settleCnt = 0;
  int excCnt = 0;
  logic svBusy = 1'b0, svOsc = 1'b0, svWatch = 1'b0, svSrc = 1'b0;
  logic [2:0] svMode = 3'd0;

  always @(negedge clk) begin
    if (svBusy && (svMode == 3'd3 || svMode == 3'd5) && svOsc) settleCnt++;
    if (svBusy && (svMode == 3'd1 || svMode == 3'd2) && (svSrc ? svWatch : svOsc)) excCnt++;
    cyc++;
    oscTick   = (cyc % 3 == 0);
    watchTick = (cyc % 7 == 0);
    svBusy  = busy;
    svMode  = mode;
    svSrc   = clkSrc;
    svOsc   = oscTick;
    svWatch = watchTick;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int divOf(input int code);
    return (code == 0) ? 1 : (1 << (code + 2));
  endfunction

  task automatic setBits(input logic [4:0] b);
    {stbySel, lowSpdOn, medSpdOn, directOn, tmrWatch} = b;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; sleepReq = 1'b0; wakeIrq = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic pulseReq();
    @(negedge clk); sleepReq = 1'b1;
    @(negedge clk); sleepReq = 1'b0; #1;
  endtask

  task automatic pulseWake();
    @(negedge clk); wakeIrq = 1'b1;
    @(negedge clk); wakeIrq = 1'b0; #1;
  endtask

  // run a direct transition; toSub selects the watch-clock route
  task automatic runDirect(input bit toSub, input int divCode, input bit disturb);
    int s0, e0, d;
    bit seen;
    d  = divOf(divCode);
    s0 = settleCnt;
    e0 = excCnt;
    pulseReq();
    check(int'(mode) == (toSub ? M_WATCH : M_SLEEP), toSub ? "R3 intermediate" : "R2 intermediate",
          int'(mode), toSub ? M_WATCH : M_SLEEP);
    check(busy == 1'b1, "R2 busy during transition", int'(busy), 1);
    if (disturb) begin
      @(negedge clk);
      sleepReq = 1'b1; wakeIrq = 1'b1; setBits(toSub ? 5'b00110 : 5'b11011);
      @(negedge clk);
      sleepReq = 1'b0; wakeIrq = 1'b0; #1;
      check(int'(mode) == (toSub ? M_WATCH : M_SLEEP), "R9 request ignored while busy",
            int'(mode), toSub ? M_WATCH : M_SLEEP);
    end
    seen = 1'b0;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk); #1;
      if (xferDone) begin seen = 1'b1; break; end
    end
    check(seen, "R6 done pulse seen", int'(seen), 1);
    check(busy == 1'b0, "R6 busy low with done", int'(busy), 0);
    check(settleCnt - s0 == 3, "R4 settle ticks", settleCnt - s0, 3);
    check(excCnt - e0 == 14 * d, "R5 exception ticks", excCnt - e0, 14 * d);
    if (!toSub)
      check((settleCnt - s0) + (excCnt - e0) == 3 + 14 * d, "R5 total oscillator periods",
            (settleCnt - s0) + (excCnt - e0), 3 + 14 * d);
    check(int'(mode) == (toSub ? M_SUB : M_MED), toSub ? "R3 final mode" : "R2 final mode",
          int'(mode), toSub ? M_SUB : M_MED);
    check(clkSrc == toSub, toSub ? "R3 clock source" : "R2 clock source", int'(clkSrc), int'(toSub));
    check(int'(divSel) == divCode, toSub ? "R3 divider" : "R2 divider", int'(divSel), divCode);
    @(negedge clk); #1;
    check(xferDone == 1'b0, "R6 single-cycle done", int'(xferDone), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    doReset();
    check(int'(mode) == M_HI, "R1 reset mode", int'(mode), M_HI);
    check(clkSrc == 1'b0, "R1 reset source", int'(clkSrc), 0);
    check(divSel == 2'd0, "R1 reset divider", int'(divSel), 0);
    check(busy == 1'b0 && xferDone == 1'b0, "R1 reset busy/done", int'({busy, xferDone}), 0);

    // sweep all control-bit combinations from high-speed active
    for (int b = 0; b < 32; b++) begin
      bit st, lo, md, dr, tw;
      int expPark;
      doReset();
      medDiv = 2'd1; subDiv = 2'd1;
      setBits(5'(b));
      {st, lo, md, dr, tw} = 5'(b);
      if (dr && !st && !lo && md) runDirect(1'b0, 1, 1'b0);
      else if (dr && st && tw && lo) runDirect(1'b1, 1, 1'b0);
      else begin
        if (dr || !st) expPark = M_SLEEP;
        else if (tw)   expPark = M_WATCH;
        else           expPark = M_STBY;
        pulseReq();
        check(int'(mode) == expPark, dr ? "R8 fallback mode" : "R7 plain mode", int'(mode), expPark);
        repeat (20) @(negedge clk);
        #1;
        check(int'(mode) == expPark, "R7 mode held until wake", int'(mode), expPark);
        check(clkSrc == 1'b0 && divSel == 2'd0 && busy == 1'b0, "R8 clock unchanged",
              int'({busy, clkSrc, divSel}), 0);
        pulseWake();
        check(int'(mode) == M_HI, "R7 return on wake", int'(mode), M_HI);
      end
    end

    // divider sweep on both routes
    for (int c = 0; c < 4; c++) begin
      doReset(); medDiv = 2'(c); setBits(5'b00110); runDirect(1'b0, c, 1'b0);
      doReset(); subDiv = 2'(c); setBits(5'b11011); runDirect(1'b1, c, 1'b0);
    end

    // requests from medium-speed active
    doReset(); medDiv = 2'd2; subDiv = 2'd1; setBits(5'b00110); runDirect(1'b0, 2, 1'b0);
    setBits(5'b11011);
    pulseReq();
    check(int'(mode) == M_SLEEP, "R8 non-high-speed fallback", int'(mode), M_SLEEP);
    check(clkSrc == 1'b0 && divSel == 2'd2, "R8 clock kept", int'({clkSrc, divSel}), 2);
    pulseWake();
    check(int'(mode) == M_MED, "R8 wake returns to medium", int'(mode), M_MED);
    setBits(5'b10000);
    pulseReq();
    check(int'(mode) == M_STBY, "R7 standby from medium", int'(mode), M_STBY);
    setBits(5'b00000);
    pulseReq();
    check(int'(mode) == M_STBY, "R9 request ignored while parked", int'(mode), M_STBY);
    pulseWake();
    check(int'(mode) == M_MED && divSel == 2'd2, "R7 wake returns to medium", int'(mode), M_MED);

    // disturbance mid-transition
    doReset(); medDiv = 2'd1; subDiv = 2'd2; setBits(5'b00110); runDirect(1'b0, 1, 1'b1);
    doReset(); medDiv = 2'd3; subDiv = 2'd0; setBits(5'b11011); runDirect(1'b1, 0, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule